// File: doc/BRIEF.md
# Circular and Reverse-Carry Pointer Update Unit

This unit works out the next value of a 16-bit indirect data pointer after each access. There are two data address spaces, X and Y, and each has its own pointer path. Both paths can run as a circular buffer. A lower and an upper word address bound the buffer. When a step carries the pointer past either bound, hardware folds it back inside the buffer, so no extra cycle and no software bound check is needed. The circular mode on the X path serves every kind of access, not only operand fetches for signal processing.

The X path has a second mode: reverse-carry stepping. Here a modifier is added with the carry running from the most significant bit toward the least significant bit, inside the field that the highest set bit of the modifier selects. Bits above that field do not change. Walking a buffer this way produces the bit-reversed order that a radix-2 FFT needs. Addresses are byte addresses of 16-bit words, so bit 0 of every result is zero.

The result is registered. It appears one clock after an access is signalled and holds its value while there is no access.

Top module: `agu_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, both `x_next` and `y_next` read 0x0000.
- R2: With circular and reverse-carry modes both off, the next pointer is pointer plus the signed step, modulo 2^16, with bit 0 forced to 0.
- R3: In circular mode with a non-negative step, a sum above the upper bound `hi` wraps to `lo + (sum - hi - 2)`. This equals the sum minus the buffer length `hi - lo + 2`.
- R4: In circular mode with a negative step, a sum below the lower bound `lo` wraps to `hi - (lo - sum - 2)`. This equals the sum plus the buffer length.
- R5: In circular mode, a sum that lies within `[lo, hi]`, the bounds themselves included, passes through unchanged with bit 0 cleared.
- R6: The X and Y paths each use only their own bounds, step and pointer. Both may update in the same cycle without affecting each other.
- R7: In reverse-carry mode, let k be the position of the highest set bit of `x_brev_mod`, with k ≥ 1. Bits k down to 1 of the next pointer are the sum of the pointer's bits and the modifier's bits in that field, with the carry flowing from bit k toward bit 1. Any carry out of bit 1 is dropped.
- R8: In reverse-carry mode, pointer bits above k are copied unchanged.
- R9: When `x_brev_en` and `x_circ_en` are both high, reverse-carry mode decides the X result.
- R10: While a path's access strobe is low, its output holds its previous value, whatever its other inputs do.
- R11: A result appears on the output one clock edge after the access strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_acc | input | 1 | X access strobe; updates `x_next` |
| x_ptr | input | 16 | Current X pointer |
| x_step | input | 16 | Signed X step in bytes |
| x_circ_en | input | 1 | Enables the circular mode on X |
| x_lo | input | 16 | X buffer lower bound (first word) |
| x_hi | input | 16 | X buffer upper bound (last word) |
| x_brev_en | input | 1 | Enables the reverse-carry mode on X |
| x_brev_mod | input | 16 | Reverse-carry modifier |
| y_acc | input | 1 | Y access strobe; updates `y_next` |
| y_ptr | input | 16 | Current Y pointer |
| y_step | input | 16 | Signed Y step in bytes |
| y_circ_en | input | 1 | Enables the circular mode on Y |
| y_lo | input | 16 | Y buffer lower bound |
| y_hi | input | 16 | Y buffer upper bound |
| x_next | output | 16 | Registered next X pointer |
| y_next | output | 16 | Registered next Y pointer |

## Verification
Two things can meet in a single cycle. On X, both mode enables can be high at once. Separately, X and Y can each wrap on the same edge. The bench provokes the first with a vector in which `x_ptr` sits at `x_hi` with both enables set. That pointer gives one answer under reverse-carry stepping (0x0810) and a different one under circular wrap (0x0800), so the sampled output shows which mode took control. For the second, the bench strobes both paths together: X wraps upward while Y wraps downward against its own bounds. Each output is then compared with the value worked out from its own path's bounds alone.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int unsigned AGU_AW = 16;

    typedef enum logic [1:0] {
        STEP_LINEAR = 2'd0,
        STEP_CIRC   = 2'd1,
        STEP_BREV   = 2'd2
    } step_mode_e;
endpackage

// File: rtl/agu_circ_step.sv
module agu_circ_step #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic          circ_en,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] nxt
);
    localparam int unsigned SW = AW + 2;

    logic signed [SW-1:0] sum_w, lo_w, hi_w, len_w, res_w;

    always_comb begin
        sum_w = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
        lo_w  = $signed({2'b00, lo});
        hi_w  = $signed({2'b00, hi});
        len_w = hi_w - lo_w + SW'(2);
        res_w = sum_w;
        if (circ_en && !step[AW-1] && (sum_w > hi_w)) begin
            res_w = sum_w - len_w;
        end else if (circ_en && step[AW-1] && (sum_w < lo_w)) begin
            res_w = sum_w + len_w;
        end
        nxt = {res_w[AW-1:1], 1'b0};
    end
endmodule

// File: rtl/agu_brev_step.sv
module agu_brev_step #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] modv,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] fld_mask
);
    int unsigned top_bit;
    logic        found;
    logic        cy;

    always_comb begin
        top_bit = 0;
        found   = 1'b0;
        for (int i = AW - 1; i >= 1; i--) begin
            if (!found && modv[i]) begin
                top_bit = i;
                found   = 1'b1;
            end
        end

        fld_mask = '0;
        for (int i = 1; i < AW; i++) begin
            fld_mask[i] = found && (i <= top_bit);
        end

        cy  = 1'b0;
        nxt = '0;
        for (int i = AW - 1; i >= 1; i--) begin
            if (fld_mask[i]) begin
                nxt[i] = ptr[i] ^ modv[i] ^ cy;
                cy     = (ptr[i] & modv[i]) | (cy & (ptr[i] ^ modv[i]));
            end else begin
                nxt[i] = ptr[i];
            end
        end
        nxt[0] = 1'b0;
    end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter int unsigned AW = AGU_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_acc,
    input  logic [AW-1:0] x_ptr,
    input  logic [AW-1:0] x_step,
    input  logic          x_circ_en,
    input  logic [AW-1:0] x_lo,
    input  logic [AW-1:0] x_hi,
    input  logic          x_brev_en,
    input  logic [AW-1:0] x_brev_mod,
    input  logic          y_acc,
    input  logic [AW-1:0] y_ptr,
    input  logic [AW-1:0] y_step,
    input  logic          y_circ_en,
    input  logic [AW-1:0] y_lo,
    input  logic [AW-1:0] y_hi,
    output logic [AW-1:0] x_next,
    output logic [AW-1:0] y_next
);
    localparam int unsigned NSP = 2;

    typedef struct packed {
        logic [AW-1:0] x_ptr;
        logic [AW-1:0] y_ptr;
    } agu_state_t;

    agu_state_t st_d, st_q;

    logic [NSP-1:0][AW-1:0] sp_ptr, sp_step, sp_lo, sp_hi, sp_circ_nxt;
    logic [NSP-1:0]         sp_circ_en;
    logic [AW-1:0]          x_brev_nxt, x_fld_mask;
    step_mode_e             x_mode;

    assign sp_ptr     = {y_ptr, x_ptr};
    assign sp_step    = {y_step, x_step};
    assign sp_lo      = {y_lo, x_lo};
    assign sp_hi      = {y_hi, x_hi};
    assign sp_circ_en = {y_circ_en, x_circ_en};

    for (genvar s = 0; s < NSP; s++) begin : g_space
        agu_circ_step #(.AW(AW)) u_circ (
            .ptr     (sp_ptr[s]),
            .step    (sp_step[s]),
            .circ_en (sp_circ_en[s]),
            .lo      (sp_lo[s]),
            .hi      (sp_hi[s]),
            .nxt     (sp_circ_nxt[s])
        );
    end

    agu_brev_step #(.AW(AW)) u_brev (
        .ptr      (x_ptr),
        .modv     (x_brev_mod),
        .nxt      (x_brev_nxt),
        .fld_mask (x_fld_mask)
    );

    always_comb begin
        if (x_brev_en)      x_mode = STEP_BREV;
        else if (x_circ_en) x_mode = STEP_CIRC;
        else                x_mode = STEP_LINEAR;

        st_d = st_q;
        if (x_acc) begin
            st_d.x_ptr = (x_mode == STEP_BREV) ? x_brev_nxt : sp_circ_nxt[0];
        end
        if (y_acc) begin
            st_d.y_ptr = sp_circ_nxt[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_next = st_q.x_ptr;
    assign y_next = st_q.y_ptr;

    assert_linear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_acc && !x_circ_en && !x_brev_en) |=>
            (x_next == (($past(x_ptr) + $past(x_step)) & ~AW'(1))));

    assert_x_in_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_acc && x_circ_en && !x_brev_en && x_ptr >= x_lo && x_ptr <= x_hi
         && !x_ptr[0] && !x_lo[0] && !x_hi[0] && x_lo < x_hi
         && (x_step[AW-1] ? (AW'(0) - x_step) : x_step) <= (x_hi - x_lo + AW'(2))) |=>
            (x_next >= $past(x_lo) && x_next <= $past(x_hi)));

    assert_y_in_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (y_acc && y_circ_en && y_ptr >= y_lo && y_ptr <= y_hi
         && !y_ptr[0] && !y_lo[0] && !y_hi[0] && y_lo < y_hi
         && (y_step[AW-1] ? (AW'(0) - y_step) : y_step) <= (y_hi - y_lo + AW'(2))) |=>
            (y_next >= $past(y_lo) && y_next <= $past(y_hi)));

    assert_brev_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (x_acc && x_brev_en) |=>
            (((x_next ^ $past(x_ptr)) & ~($past(x_fld_mask) | AW'(1))) == '0));

    assert_hold_x_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !x_acc |=> $stable(x_next));

    assert_hold_y_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !y_acc |=> $stable(y_next));

    assert_lsb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_acc || y_acc) |=> (!x_next[0] && !y_next[0]));
endmodule

// File: tb/tb_agu_addr_gen.sv
module tb_agu_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        x_acc, x_circ_en, x_brev_en, y_acc, y_circ_en;
    logic [15:0] x_ptr, x_step, x_lo, x_hi, x_brev_mod;
    logic [15:0] y_ptr, y_step, y_lo, y_hi;
    logic [15:0] x_next, y_next;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    agu_addr_gen dut (
        .clk(clk), .rst_n(rst_n),
        .x_acc(x_acc), .x_ptr(x_ptr), .x_step(x_step), .x_circ_en(x_circ_en),
        .x_lo(x_lo), .x_hi(x_hi), .x_brev_en(x_brev_en), .x_brev_mod(x_brev_mod),
        .y_acc(y_acc), .y_ptr(y_ptr), .y_step(y_step), .y_circ_en(y_circ_en),
        .y_lo(y_lo), .y_hi(y_hi),
        .x_next(x_next), .y_next(y_next)
    );

    typedef struct packed {
        logic [15:0] ptr;
        logic [15:0] step;
        logic        circ;
        logic        brev;
        logic [15:0] bmod;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    // X bounds for every row: lo 0x0800, hi 0x081E (length 0x20)
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 16'h0002, 1'b0, 1'b0, 16'h0000, 16'h1236, 4'd2},  // R2
        '{16'h1234, 16'hFFFC, 1'b0, 1'b0, 16'h0000, 16'h1230, 4'd2},  // R2 negative
        '{16'h1235, 16'h0002, 1'b0, 1'b0, 16'h0000, 16'h1236, 4'd2},  // R2 bit0 cleared
        '{16'hFFFE, 16'h0004, 1'b0, 1'b0, 16'h0000, 16'h0002, 4'd2},  // R2 wraps 2^16
        '{16'h0810, 16'h0002, 1'b1, 1'b0, 16'h0000, 16'h0812, 4'd5},  // R5
        '{16'h081A, 16'h0004, 1'b1, 1'b0, 16'h0000, 16'h081E, 4'd5},  // R5 lands on hi
        '{16'h0802, 16'hFFFE, 1'b1, 1'b0, 16'h0000, 16'h0800, 4'd5},  // R5 lands on lo
        '{16'h081E, 16'h0002, 1'b1, 1'b0, 16'h0000, 16'h0800, 4'd3},  // R3
        '{16'h081C, 16'h0006, 1'b1, 1'b0, 16'h0000, 16'h0802, 4'd3},  // R3 overshoot
        '{16'h0800, 16'hFFFE, 1'b1, 1'b0, 16'h0000, 16'h081E, 4'd4},  // R4
        '{16'h0802, 16'hFFFA, 1'b1, 1'b0, 16'h0000, 16'h081C, 4'd4},  // R4 undershoot
        '{16'h1000, 16'h0002, 1'b0, 1'b1, 16'h0008, 16'h1008, 4'd7},  // R7
        '{16'h1008, 16'h0002, 1'b0, 1'b1, 16'h0008, 16'h1004, 4'd7},  // R7 carry down
        '{16'hABC6, 16'h0002, 1'b0, 1'b1, 16'h0008, 16'hABCE, 4'd8},  // R8 upper kept
        '{16'h081E, 16'h0002, 1'b1, 1'b1, 16'h0008, 16'h0810, 4'd9},  // R9 precedence
        '{16'h2010, 16'h0002, 1'b0, 1'b1, 16'h0010, 16'h2008, 4'd7}   // R7 16 points
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] rev4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] held;
        logic [15:0] bp;
        rst_n = 1'b0; x_acc = 1'b0; y_acc = 1'b0;
        x_ptr = 16'h1234; x_step = 16'h0002; x_circ_en = 1'b0; x_brev_en = 1'b0;
        x_lo = 16'h0800; x_hi = 16'h081E; x_brev_mod = 16'h0008;
        y_ptr = 16'h0402; y_step = 16'h0002; y_circ_en = 1'b1;
        y_lo = 16'h0400; y_hi = 16'h040E;
        repeat (3) @(negedge clk);
        x_acc = 1'b1; y_acc = 1'b1;
        @(negedge clk);
        check("R1 x reset", x_next, 16'h0000);
        check("R1 y reset", y_next, 16'h0000);
        rst_n = 1'b1;
        x_acc = 1'b0; y_acc = 1'b0;
        @(negedge clk);
        check("R1 x after reset", x_next, 16'h0000);

        // table walk, one result per cycle (R11 latency)
        for (int i = 0; i < NV; i++) begin
            x_acc = 1'b1;
            x_ptr = VECS[i].ptr; x_step = VECS[i].step;
            x_circ_en = VECS[i].circ; x_brev_en = VECS[i].brev;
            x_brev_mod = VECS[i].bmod;
            @(negedge clk);
            check($sformatf("R%0d/R11 vector %0d", VECS[i].req, i), x_next, VECS[i].exp);
        end

        // R7 full 16-point reverse-carry walk against a bit-reversal model
        bp = 16'h3000;
        x_brev_en = 1'b1; x_circ_en = 1'b0; x_brev_mod = 16'h0010;
        for (int j = 0; j < 16; j++) begin
            x_ptr = bp;
            @(negedge clk);
            check("R7 walk", x_next, {bp[15:5], rev4(rev4(bp[4:1]) + 4'd1), 1'b0});
            bp = x_next;
        end

        // R6: X and Y wrap on the same edge, each against its own bounds
        x_brev_en = 1'b0; x_circ_en = 1'b1;
        x_ptr = 16'h081E; x_step = 16'h0002;
        y_acc = 1'b1; y_ptr = 16'h0400; y_step = 16'hFFFE;
        @(negedge clk);
        check("R6 x wrap up", x_next, 16'h0800);
        check("R6 y wrap down", y_next, 16'h040E);
        x_ptr = 16'h0810; y_ptr = 16'h040E; y_step = 16'h0004;
        @(negedge clk);
        check("R6 x inside", x_next, 16'h0812);
        check("R6 y wrap up", y_next, 16'h0402);
        y_circ_en = 1'b0; y_ptr = 16'h040E; y_step = 16'h0004;
        @(negedge clk);
        check("R2 y linear", y_next, 16'h0412);

        // R10: no strobe, inputs change, outputs hold
        held = x_next;
        x_acc = 1'b0; y_acc = 1'b0;
        x_ptr = 16'h5550; y_ptr = 16'h6660; x_brev_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 x hold", x_next, held);
        check("R10 y hold", y_next, 16'h0412);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule